// File: doc/BRIEF.md
# Paired-View Floating-Point Register File

This block holds the floating-point operand registers of a processor core: 32 entries of 64 bits each, reached through one write port and three combinational read ports. Every access names a 5-bit register number and a size, either a 32-bit word (single precision or integer word) or a 64-bit doubleword (double precision or long).

A single mode input chooses how register numbers map onto storage. With the mode input high (flat view), each register number owns its own 64-bit entry, and a word access uses the low half of that entry. With the mode input low (paired view), an even register and the odd register above it share one entry. The even number names the low half and the odd number names the high half. Doubleword accesses in this view ignore bit 0 of the register number.

A word write always leaves the other half of its entry unchanged. The mode input only steers addressing, so the same stored bits can be read under either view. Each read port returns both the word and the doubleword view of its register number, and the consumer picks the one it needs.

Top module: `fpr_pair_regfile`

## Requirements
- R1: A word read returns bits 31:0 of entry[n] when the mode input is high, or when register number n is even.
- R2: With the mode input low and n odd, a word read returns bits 63:32 of entry[n with bit 0 cleared].
- R3: A word write (wr_dbl = 0) replaces only the addressed 32-bit half with wr_data[31:0] and keeps the other half of that entry and all other entries unchanged.
- R4: With the mode input low, doubleword reads and writes use entry[n with bit 0 cleared]; with it high they use entry[n], and no other entry is touched.
- R5: A doubleword write (wr_dbl = 1) replaces all 64 bits of the selected entry with wr_data.
- R6: Writes take effect on the rising clock edge only while wr_en is high; with wr_en low the stored contents do not change, whatever wr_data, wr_idx and wr_dbl show.
- R7: Read ports are combinational. A read in the same cycle as a write to the same location returns the old contents, and the new value is visible from the next cycle.
- R8: A synchronous active-high reset clears every entry to zero and blocks any write in that cycle.
- R9: Changing the mode input does not change stored data; it only changes which bits each register number reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| flat_mode | input | 1 | 1: every register number owns an entry; 0: even/odd pairs share an entry |
| wr_en | input | 1 | Write enable |
| wr_dbl | input | 1 | Write size: 0 word, 1 doubleword |
| wr_idx | input | 5 | Write register number |
| wr_data | input | 64 | Write data; a word write uses bits 31:0 |
| rd_idx | input | 15 | Read register numbers, port p in bits 5p+4:5p |
| rd_word | output | 96 | Word view per port, port p in bits 32p+31:32p |
| rd_dword | output | 192 | Doubleword view per port, port p in bits 64p+63:64p |

## Verification
A wrong half-select or a lost bit-0 clear shows up at the read ports in the cycle right after the write that hit the wrong location. This happens either as a changed neighbour half or as a value appearing under the wrong register number. The stimulus alternates the view between writes and reads, so that data written in one view is read back in the other. Stale or disturbed contents also show as soon as any port addresses the affected entry, so the reset sweep reads all entries back.

// File: rtl/fpr_pkg.sv
package fpr_pkg;

    parameter int unsigned FPR_ENTRIES = 32;
    parameter int unsigned WORD_W      = 32;
    parameter int unsigned DWORD_W     = 2 * WORD_W;
    parameter int unsigned IDX_W       = $clog2(FPR_ENTRIES);
    parameter int unsigned RD_PORTS    = 3;

    typedef enum logic {
        ACC_WORD  = 1'b0,
        ACC_DWORD = 1'b1
    } acc_size_e;

    typedef struct packed {
        logic [IDX_W-1:0] entry;
        logic             upper;
    } fpr_loc_t;

    typedef logic [FPR_ENTRIES-1:0][DWORD_W-1:0] fpr_array_t;

    function automatic fpr_loc_t locate(input logic [IDX_W-1:0] idx,
                                        input acc_size_e        size,
                                        input logic             flat);
        fpr_loc_t loc;
        if (flat) begin
            loc.entry = idx;
            loc.upper = 1'b0;
        end else begin
            loc.entry = {idx[IDX_W-1:1], 1'b0};
            loc.upper = (size == ACC_WORD) && idx[0];
        end
        return loc;
    endfunction

endpackage

// File: rtl/fpr_addr_map.sv
module fpr_addr_map
    import fpr_pkg::*;
(
    input  logic [IDX_W-1:0] idx,
    input  acc_size_e        size,
    input  logic             flat,
    output fpr_loc_t         loc
);

    always_comb begin
        loc = locate(idx, size, flat);
    end

endmodule

// File: rtl/fpr_storage.sv
module fpr_storage
    import fpr_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic [FPR_ENTRIES-1:0] we_lo,
    input  logic [FPR_ENTRIES-1:0] we_hi,
    input  logic [WORD_W-1:0]      din_lo,
    input  logic [WORD_W-1:0]      din_hi,
    output fpr_array_t             mem_q
);

    for (genvar e = 0; e < FPR_ENTRIES; e++) begin : g_entry
        always_ff @(posedge clk) begin
            if (rst) begin
                mem_q[e] <= '0;
            end else begin
                if (we_lo[e]) mem_q[e][WORD_W-1:0]       <= din_lo;
                if (we_hi[e]) mem_q[e][DWORD_W-1:WORD_W] <= din_hi;
            end
        end

        AST_LO_HELD: assert property (@(posedge clk) disable iff (rst)
            !we_lo[e] |=> $stable(mem_q[e][WORD_W-1:0])); // R3
        AST_HI_HELD: assert property (@(posedge clk) disable iff (rst)
            !we_hi[e] |=> $stable(mem_q[e][DWORD_W-1:WORD_W])); // R3
    end

    AST_ONE_LO: assert property (@(posedge clk) disable iff (rst)
        $onehot0(we_lo)); // R4
    AST_ONE_HI: assert property (@(posedge clk) disable iff (rst)
        $onehot0(we_hi)); // R4

endmodule

// File: rtl/fpr_read_port.sv
module fpr_read_port
    import fpr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  fpr_array_t       mem_q,
    input  logic [IDX_W-1:0] idx,
    input  logic             flat,
    output logic [WORD_W-1:0]  word_o,
    output logic [DWORD_W-1:0] dword_o
);

    fpr_loc_t loc_w;
    fpr_loc_t loc_d;

    fpr_addr_map u_map_word (
        .idx  (idx),
        .size (ACC_WORD),
        .flat (flat),
        .loc  (loc_w)
    );

    fpr_addr_map u_map_dword (
        .idx  (idx),
        .size (ACC_DWORD),
        .flat (flat),
        .loc  (loc_d)
    );

    logic [DWORD_W-1:0] word_src;

    always_comb begin
        word_src = mem_q[loc_w.entry];
        word_o   = loc_w.upper ? word_src[DWORD_W-1:WORD_W]
                               : word_src[WORD_W-1:0];
        dword_o  = mem_q[loc_d.entry];
    end

    AST_WORD_LOW: assert property (@(posedge clk) disable iff (rst)
        (flat || !idx[0]) |-> word_o == dword_o[WORD_W-1:0]); // R1
    AST_WORD_HIGH: assert property (@(posedge clk) disable iff (rst)
        (!flat && idx[0]) |-> word_o == dword_o[DWORD_W-1:WORD_W]); // R2

endmodule

// File: rtl/fpr_pair_regfile.sv
module fpr_pair_regfile
    import fpr_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          flat_mode,
    input  logic                          wr_en,
    input  logic                          wr_dbl,
    input  logic [IDX_W-1:0]              wr_idx,
    input  logic [DWORD_W-1:0]            wr_data,
    input  logic [RD_PORTS*IDX_W-1:0]     rd_idx,
    output logic [RD_PORTS*WORD_W-1:0]    rd_word,
    output logic [RD_PORTS*DWORD_W-1:0]   rd_dword
);

    acc_size_e               wr_size;
    fpr_loc_t                wr_loc;
    logic [FPR_ENTRIES-1:0]  we_lo;
    logic [FPR_ENTRIES-1:0]  we_hi;
    logic [WORD_W-1:0]       din_lo;
    logic [WORD_W-1:0]       din_hi;
    fpr_array_t              mem_q;

    assign wr_size = acc_size_e'(wr_dbl);

    fpr_addr_map u_wr_map (
        .idx  (wr_idx),
        .size (wr_size),
        .flat (flat_mode),
        .loc  (wr_loc)
    );

    always_comb begin
        we_lo  = '0;
        we_hi  = '0;
        din_lo = wr_data[WORD_W-1:0];
        din_hi = (wr_size == ACC_DWORD) ? wr_data[DWORD_W-1:WORD_W]
                                        : wr_data[WORD_W-1:0];
        if (wr_en) begin
            if (wr_size == ACC_DWORD) begin
                we_lo[wr_loc.entry] = 1'b1;
                we_hi[wr_loc.entry] = 1'b1;
            end else if (wr_loc.upper) begin
                we_hi[wr_loc.entry] = 1'b1;
            end else begin
                we_lo[wr_loc.entry] = 1'b1;
            end
        end
    end

    fpr_storage u_store (
        .clk    (clk),
        .rst    (rst),
        .we_lo  (we_lo),
        .we_hi  (we_hi),
        .din_lo (din_lo),
        .din_hi (din_hi),
        .mem_q  (mem_q)
    );

    for (genvar p = 0; p < RD_PORTS; p++) begin : g_rd
        fpr_read_port u_port (
            .clk     (clk),
            .rst     (rst),
            .mem_q   (mem_q),
            .idx     (rd_idx[p*IDX_W +: IDX_W]),
            .flat    (flat_mode),
            .word_o  (rd_word[p*WORD_W +: WORD_W]),
            .dword_o (rd_dword[p*DWORD_W +: DWORD_W])
        );
    end

    AST_WORD_WR_ONE_HALF: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_dbl) |-> $countones({we_lo, we_hi}) == 1); // R3
    AST_DWORD_WR_BOTH: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_dbl) |-> (we_lo == we_hi) && $countones(we_lo) == 1); // R5
    AST_IDLE_NO_WE: assert property (@(posedge clk) disable iff (rst)
        !wr_en |-> (we_lo == '0) && (we_hi == '0)); // R6
    AST_RAW_NEXT: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_dbl && flat_mode && rd_idx[IDX_W-1:0] == wr_idx)
        |=> (!$stable(rd_idx[IDX_W-1:0]) || !$stable(flat_mode)
             || rd_dword[DWORD_W-1:0] == $past(wr_data))); // R7
    AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> rd_dword == '0); // R8

endmodule

// File: tb/test_fpr_pair_regfile.sv
`timescale 1ns/1ps
module test_fpr_pair_regfile;
    import fpr_pkg::*;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic                        rst;
    logic                        flat_mode;
    logic                        wr_en;
    logic                        wr_dbl;
    logic [4:0]                  wr_idx;
    logic [63:0]                 wr_data;
    logic [RD_PORTS*IDX_W-1:0]   rd_idx;
    logic [RD_PORTS*WORD_W-1:0]  rd_word;
    logic [RD_PORTS*DWORD_W-1:0] rd_dword;

    fpr_pair_regfile i_fpr_pair_regfile (
        .clk       (clk),
        .rst       (rst),
        .flat_mode (flat_mode),
        .wr_en     (wr_en),
        .wr_dbl    (wr_dbl),
        .wr_idx    (wr_idx),
        .wr_data   (wr_data),
        .rd_idx    (rd_idx),
        .rd_word   (rd_word),
        .rd_dword  (rd_dword)
    );

    int n_cmp  = 0;
    int n_bad  = 0;
    bit done   = 0;

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    typedef struct packed {
        logic        mode;
        logic        we;
        logic        dbl;
        logic [4:0]  widx;
        logic [63:0] wdata;
        logic [4:0]  ridx;
        logic [31:0] ew;
        logic [63:0] ed;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 1'b1, 1'b1, 5'd4, 64'h1111_2222_3333_4444, 5'd4, 32'h3333_4444, 64'h1111_2222_3333_4444, 4'd5},  // R5
        '{1'b0, 1'b1, 1'b0, 5'd5, 64'h0000_0000_AAAA_5555, 5'd5, 32'hAAAA_5555, 64'hAAAA_5555_3333_4444, 4'd2},  // R2
        '{1'b0, 1'b1, 1'b0, 5'd4, 64'hFFFF_FFFF_BBBB_0000, 5'd4, 32'hBBBB_0000, 64'hAAAA_5555_BBBB_0000, 4'd3},  // R3
        '{1'b1, 1'b0, 1'b1, 5'd4, 64'hFFFF_FFFF_FFFF_FFFF, 5'd4, 32'hBBBB_0000, 64'hAAAA_5555_BBBB_0000, 4'd6},  // R6
        '{1'b1, 1'b0, 1'b0, 5'd0, 64'h0,                   5'd5, 32'h0,         64'h0,                   4'd9},  // R9
        '{1'b1, 1'b1, 1'b0, 5'd7, 64'h0000_0000_7777_0007, 5'd7, 32'h7777_0007, 64'h0000_0000_7777_0007, 4'd1},  // R1
        '{1'b0, 1'b1, 1'b1, 5'd7, 64'h6666_6666_EEEE_EEEE, 5'd7, 32'h6666_6666, 64'h6666_6666_EEEE_EEEE, 4'd4},  // R4
        '{1'b1, 1'b0, 1'b0, 5'd0, 64'h0,                   5'd7, 32'h7777_0007, 64'h0000_0000_7777_0007, 4'd4},  // R4
        '{1'b1, 1'b1, 1'b1, 5'd3, 64'h0123_4567_89AB_CDEF, 5'd3, 32'h89AB_CDEF, 64'h0123_4567_89AB_CDEF, 4'd5},  // R5
        '{1'b0, 1'b1, 1'b0, 5'd3, 64'h0000_0000_CAFE_F00D, 5'd2, 32'h0,         64'hCAFE_F00D_0000_0000, 4'd3},  // R3
        '{1'b1, 1'b0, 1'b0, 5'd0, 64'h0,                   5'd3, 32'h89AB_CDEF, 64'h0123_4567_89AB_CDEF, 4'd3},  // R3
        '{1'b0, 1'b1, 1'b0, 5'd0, 64'h0000_0000_1234_5678, 5'd1, 32'h0,         64'h0000_0000_1234_5678, 4'd2}   // R2
    };

    initial begin
        #(100000 * 4);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; flat_mode = 1'b1; wr_en = 1'b0; wr_dbl = 1'b0;
        wr_idx = '0; wr_data = '0; rd_idx = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // reset state: R8
        rd_idx = {5'd31, 5'd9, 5'd0};
        #1;
        check("R8 reset p0", rd_dword[63:0], 64'h0);
        check("R8 reset p1", rd_dword[127:64], 64'h0);
        check("R8 reset p2", rd_dword[191:128], 64'h0);

        for (int v = 0; v < NV; v++) begin
            @(negedge clk);
            flat_mode = VECS[v].mode;
            wr_en     = VECS[v].we;
            wr_dbl    = VECS[v].dbl;
            wr_idx    = VECS[v].widx;
            wr_data   = VECS[v].wdata;
            rd_idx    = {10'd0, VECS[v].ridx};
            @(negedge clk);
            wr_en = 1'b0;
            #1;
            check($sformatf("R%0d vec%0d word", VECS[v].req, v), {32'h0, rd_word[31:0]}, {32'h0, VECS[v].ew});
            check($sformatf("R%0d vec%0d dword", VECS[v].req, v), rd_dword[63:0], VECS[v].ed);
        end

        // R7: same-cycle read returns old contents, new value next cycle
        @(negedge clk);
        flat_mode = 1'b1; wr_en = 1'b1; wr_dbl = 1'b1; wr_idx = 5'd10;
        wr_data = 64'hDEAD_BEEF_0BAD_F00D; rd_idx = {5'd10, 5'd10, 5'd10};
        #1;
        check("R7 old during write", rd_dword[63:0], 64'h0);
        check("R7 old during write p2", rd_dword[191:128], 64'h0);
        @(negedge clk);
        wr_en = 1'b0;
        #1;
        check("R7 new next cycle", rd_dword[127:64], 64'hDEAD_BEEF_0BAD_F00D);

        // R2 / R1 on other ports in paired view
        flat_mode = 1'b0; rd_idx = {5'd11, 5'd10, 5'd0};
        #1;
        check("R2 port2 odd pair", {32'h0, rd_word[95:64]}, 64'h0000_0000_DEAD_BEEF);
        check("R1 port1 even pair", {32'h0, rd_word[63:32]}, 64'h0000_0000_0BAD_F00D);

        // R8: reset wins over a simultaneous write and clears everything
        @(negedge clk);
        rst = 1'b1; wr_en = 1'b1; wr_dbl = 1'b1; wr_idx = 5'd12; wr_data = 64'h5A5A_5A5A_5A5A_5A5A;
        flat_mode = 1'b1;
        @(negedge clk);
        rst = 1'b0; wr_en = 1'b0;
        for (int e = 0; e < 32; e += 3) begin
            rd_idx = {5'((e + 2) % 32), 5'((e + 1) % 32), 5'(e)};
            #1;
            check($sformatf("R8 clear %0d", e), rd_dword[63:0], 64'h0);
            check($sformatf("R8 clear %0d", e + 1), rd_dword[127:64], 64'h0);
            check($sformatf("R8 clear %0d", e + 2), rd_dword[191:128], 64'h0);
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule